// File: doc/BRIEF.md
# Nibble-Access Timer and Event Counter

This block holds an 8-bit binary up counter for a small 4-bit processor core. A static mode input picks what advances it. In timer mode it steps once for every cycle in which an internal tick pulse is high. In event mode it steps once for every rising edge seen on an external counter pin. That pin is first passed through a two-flop synchronizer and then through a small edge-detecting state machine.

The core's decoder drives a 3-bit operation code, and the counter value moves across its 4-bit data path one nibble at a time. The upper nibble is loaded from the accumulator and the lower nibble from the selected memory digit. For reads, the upper nibble is written back to the memory digit and the lower nibble to the accumulator. When the counter wraps from 0xFF to 0x00 it raises a sticky overflow flag. Software polls that flag with a test-and-clear operation.

The edge detector has three states. In EV_LOW the synchronized pin has last been seen low; a high level moves it to EV_RISE, otherwise it stays. EV_RISE lasts one cycle and is the only state that steps the counter; it goes to EV_HIGH if the level is still high and back to EV_LOW if it is not. EV_HIGH stays while the level is high and goes back to EV_LOW when it drops.

The overflow flag has two states. FLG_CLEAR moves to FLG_SET on a wrap. FLG_SET goes back to FLG_CLEAR on a test-and-clear operation, unless a wrap happens in that same cycle.

Top module: `tec_timer_event`

## Requirements
- R1: While reset is low, the counter goes to 0x00, the overflow flag clears and the edge detector goes to EV_LOW.
- R2: When event_mode_i is 0, the counter rises by one at each clock edge where tick_i is 1. The counter pin has no effect in this mode.
- R3: When event_mode_i is 1, each low-to-high transition of cnt_pin_i raises the counter by exactly one. The new value is visible after the fourth rising clock edge following the change. A level held high counts once, and tick_i has no effect in this mode.
- R4: A step taken from 0xFF leaves the counter at 0x00 and sets the overflow flag.
- R5: The overflow flag stays set until a test-and-clear operation (op code 5). In the cycle of that operation, ovf_hit_o shows the flag's current value, and the flag is clear from the next cycle on. If a wrap happens in the same cycle as the test, the flag stays set.
- R6: Op code 1 loads acc_i into counter bits 7:4 and leaves bits 3:0 unchanged.
- R7: Op code 2 loads mem_i into counter bits 3:0 and leaves bits 7:4 unchanged.
- R8: A load wins over a step in the same cycle. That step is dropped, and the other nibble keeps its value.
- R9: Op code 3 drives counter bits 7:4 on mem_wdata_o with mem_we_o high, and op code 4 drives bits 3:0 on acc_wdata_o with acc_we_o high, both in the same cycle. For op codes 0, 6 and 7 all strobes and ovf_hit_o stay low and the counter is untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_mode_i | input | 1 | 0: count internal ticks, 1: count pin edges |
| tick_i | input | 1 | Internal periodic tick pulse |
| cnt_pin_i | input | 1 | Asynchronous external counter pin |
| op_i | input | 3 | Operation code (0 idle, 1 load upper, 2 load lower, 3 read upper, 4 read lower, 5 test-and-clear) |
| acc_i | input | 4 | Accumulator value for upper-nibble load |
| mem_i | input | 4 | Memory digit value for lower-nibble load |
| acc_wdata_o | output | 4 | Lower nibble toward the accumulator |
| acc_we_o | output | 1 | Accumulator write strobe |
| mem_wdata_o | output | 4 | Upper nibble toward the memory digit |
| mem_we_o | output | 1 | Memory digit write strobe |
| ovf_hit_o | output | 1 | Flag value during a test-and-clear operation |

## Verification
Read data, write strobes and ovf_hit_o are combinational. They are due in the same cycle as the operation code, so the scoreboard monitor compares them just before the next rising edge. Loads and tick steps take effect at the edge that samples them, which makes a read issued in the following cycle the first one to see the change. A pin edge reaches the counter only after the fourth edge: two synchronizer flops, the EV_RISE state, then the counter register. The bench therefore issues a lower-nibble read every cycle after raising the pin and expects the old value four times before the new one appears.

// File: rtl/tec_pkg.sv
package tec_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_LOAD_HI  = 3'd1,
        OP_LOAD_LO  = 3'd2,
        OP_READ_HI  = 3'd3,
        OP_READ_LO  = 3'd4,
        OP_TEST_CLR = 3'd5
    } tec_op_e;

    typedef enum logic [1:0] {
        EV_LOW  = 2'd0,
        EV_RISE = 2'd1,
        EV_HIGH = 2'd2
    } edge_st_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_st_e;

endpackage

// File: rtl/tec_sync.sv
module tec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= 1'b0;
                end else if (s == 0) begin
                    chain_q[s] <= d_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tec_edge_fsm.sv
module tec_edge_fsm
    import tec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    edge_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_LOW:  state_d = lvl_i ? EV_RISE : EV_LOW;
            EV_RISE: state_d = lvl_i ? EV_HIGH : EV_LOW;
            EV_HIGH: state_d = lvl_i ? EV_HIGH : EV_LOW;
            default: state_d = EV_LOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            EV_RISE: rise_o = 1'b1;
            default: rise_o = 1'b0;
        endcase
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3

    AST_HIGH_HOLDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_HIGH && lvl_i) |=> !rise_o); // R3
endmodule

// File: rtl/tec_count_core.sv
module tec_count_core
    import tec_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic [2:0]           op_i,
    input  logic [NIB_W-1:0]     acc_i,
    input  logic [NIB_W-1:0]     mem_i,
    output logic [2*NIB_W-1:0]   cnt_o,
    output logic                 flag_o
);
    localparam int CNT_W = 2 * NIB_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             load_hi, load_lo, any_load, test_clr, wrap;
    flag_st_e         flg_q, flg_d;

    assign load_hi  = (op_i == OP_LOAD_HI);
    assign load_lo  = (op_i == OP_LOAD_LO);
    assign test_clr = (op_i == OP_TEST_CLR);
    assign any_load = load_hi | load_lo;
    assign wrap     = step_i && !any_load && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_hi) begin
            cnt_q[CNT_W-1 -: NIB_W] <= acc_i;
        end else if (load_lo) begin
            cnt_q[NIB_W-1:0] <= mem_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= FLG_CLEAR;
        else        flg_q <= flg_d;
    end

    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_CLEAR: flg_d = wrap ? FLG_SET : FLG_CLEAR;
            FLG_SET:   flg_d = (test_clr && !wrap) ? FLG_CLEAR : FLG_SET;
            default:   flg_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        unique case (flg_q)
            FLG_SET: flag_o = 1'b1;
            default: flag_o = 1'b0;
        endcase
    end

    assign cnt_o = cnt_q;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag_o && cnt_q == '0)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !test_clr) |=> flag_o); // R5

    AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        load_hi |=> (cnt_q[CNT_W-1 -: NIB_W] == $past(acc_i)
                     && cnt_q[NIB_W-1:0] == $past(cnt_q[NIB_W-1:0]))); // R6

    AST_LOAD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (cnt_q[NIB_W-1:0] == $past(mem_i))); // R7

    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lo && step_i) |=> $stable(cnt_q[CNT_W-1 -: NIB_W])); // R8
endmodule

// File: rtl/tec_timer_event.sv
module tec_timer_event
    import tec_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_mode_i,
    input  logic             tick_i,
    input  logic             cnt_pin_i,
    input  logic [2:0]       op_i,
    input  logic [NIB_W-1:0] acc_i,
    input  logic [NIB_W-1:0] mem_i,
    output logic [NIB_W-1:0] acc_wdata_o,
    output logic             acc_we_o,
    output logic [NIB_W-1:0] mem_wdata_o,
    output logic             mem_we_o,
    output logic             ovf_hit_o
);
    localparam int CNT_W = 2 * NIB_W;

    logic             pin_sync, pin_rise, step;
    logic [CNT_W-1:0] cnt;
    logic             flag;

    tec_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cnt_pin_i),
        .q_o   (pin_sync)
    );

    tec_edge_fsm i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_sync),
        .rise_o (pin_rise)
    );

    assign step = event_mode_i ? pin_rise : tick_i;

    tec_count_core #(.NIB_W(NIB_W)) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .op_i   (op_i),
        .acc_i  (acc_i),
        .mem_i  (mem_i),
        .cnt_o  (cnt),
        .flag_o (flag)
    );

    always_comb begin
        acc_wdata_o = cnt[NIB_W-1:0];
        mem_wdata_o = cnt[CNT_W-1 -: NIB_W];
        acc_we_o    = 1'b0;
        mem_we_o    = 1'b0;
        ovf_hit_o   = 1'b0;
        unique case (op_i)
            OP_READ_HI:  mem_we_o  = 1'b1;
            OP_READ_LO:  acc_we_o  = 1'b1;
            OP_TEST_CLR: ovf_hit_o = flag;
            default: ;
        endcase
    end

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_we_o, mem_we_o, ovf_hit_o})); // R9

    AST_TIMER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_mode_i && !tick_i && op_i == OP_IDLE) |=> $stable(cnt)); // R2

    AST_EVENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (event_mode_i && !pin_rise && op_i == OP_IDLE) |=> $stable(cnt)); // R3
endmodule

// File: tb/test_tec_timer_event.sv
`timescale 1ns/1ps
module test_tec_timer_event;
    import tec_pkg::*;

    localparam int K_NONE = 0, K_HI = 1, K_LO = 2, K_TEST = 3, K_QUIET = 4;

    typedef struct {
        int         kind;
        logic [3:0] val;
        string      req;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       event_mode_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       cnt_pin_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [3:0] acc_i = '0;
    logic [3:0] mem_i = '0;
    logic [3:0] acc_wdata_o, mem_wdata_o;
    logic       acc_we_o, mem_we_o, ovf_hit_o;

    sb_item_t   sb_q[$];
    int         n_checks = 0;
    int         n_fails  = 0;
    logic       pin_lvl  = 1'b0;
    bit         done     = 1'b0;

    always #2.5 clk = ~clk;

    tec_timer_event i_tec_timer_event (
        .clk(clk), .rst_n(rst_n), .event_mode_i(event_mode_i),
        .tick_i(tick_i), .cnt_pin_i(cnt_pin_i), .op_i(op_i),
        .acc_i(acc_i), .mem_i(mem_i),
        .acc_wdata_o(acc_wdata_o), .acc_we_o(acc_we_o),
        .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .ovf_hit_o(ovf_hit_o)
    );

    // monitor: pops one expectation per driven cycle, samples before next edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                case (it.kind)
                    K_HI: if (!(mem_we_o && !acc_we_o && mem_wdata_o == it.val)) begin
                        n_fails++;
                        $display("FAIL %s upper read: we=%b data=%h expected we=1 data=%h",
                                 it.req, mem_we_o, mem_wdata_o, it.val);
                    end
                    K_LO: if (!(acc_we_o && !mem_we_o && acc_wdata_o == it.val)) begin
                        n_fails++;
                        $display("FAIL %s lower read: we=%b data=%h expected we=1 data=%h",
                                 it.req, acc_we_o, acc_wdata_o, it.val);
                    end
                    K_TEST: if (ovf_hit_o !== it.val[0]) begin
                        n_fails++;
                        $display("FAIL %s test-and-clear: hit=%b expected %b",
                                 it.req, ovf_hit_o, it.val[0]);
                    end
                    default: if (acc_we_o || mem_we_o || ovf_hit_o) begin
                        n_fails++;
                        $display("FAIL %s quiet cycle: strobes=%b%b%b expected 000",
                                 it.req, acc_we_o, mem_we_o, ovf_hit_o);
                    end
                endcase
            end
        end
    end

    task automatic cyc(input logic [2:0] op, input logic [3:0] a, input logic [3:0] m,
                       input logic tk, input int kind, input logic [3:0] val,
                       input string req);
        sb_item_t it;
        @(negedge clk);
        op_i = op; acc_i = a; mem_i = m; tick_i = tk; cnt_pin_i = pin_lvl;
        if (kind != K_NONE) begin
            it.kind = kind; it.val = val; it.req = req;
            sb_q.push_back(it);
        end
    endtask

    task automatic read_both(input logic [7:0] exp, input string req);
        cyc(OP_READ_HI, 4'h0, 4'h0, 1'b0, K_HI, exp[7:4], req);
        cyc(OP_READ_LO, 4'h0, 4'h0, 1'b0, K_LO, exp[3:0], req);
    endtask

    task automatic load_val(input logic [7:0] v);
        cyc(OP_LOAD_HI, v[7:4], 4'h0, 1'b0, K_NONE, 4'h0, "");
        cyc(OP_LOAD_LO, 4'h0, v[3:0], 1'b0, K_NONE, 4'h0, "");
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; event_mode_i = mode; pin_lvl = 1'b0;
        op_i = OP_IDLE; tick_i = 1'b0; cnt_pin_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // ---------------- timer mode ----------------
        do_reset(1'b0);
        read_both(8'h00, "R1");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h0, "R1");

        for (int i = 0; i < 5; i++) begin
            pin_lvl = i[0];                       // pin toggles, ignored (R2)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b1, K_QUIET, 4'h0, "R2");
        end
        pin_lvl = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pin_lvl = ~pin_lvl;
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b0, K_QUIET, 4'h0, "R2");
        end
        pin_lvl = 1'b0;
        read_both(8'h05, "R2");

        cyc(OP_LOAD_HI, 4'hF, 4'h0, 1'b0, K_NONE, 4'h0, "");
        read_both(8'hF5, "R6");
        cyc(OP_LOAD_LO, 4'h0, 4'hE, 1'b0, K_NONE, 4'h0, "");
        read_both(8'hFE, "R7");
        cyc(OP_IDLE, 4'h0, 4'h0, 1'b1, K_QUIET, 4'h0, "R2");
        read_both(8'hFF, "R2");
        cyc(OP_IDLE, 4'h0, 4'h0, 1'b1, K_QUIET, 4'h0, "R4");
        read_both(8'h00, "R4");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h1, "R4");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h0, "R5");

        // sticky across idle time
        load_val(8'hFF);
        cyc(OP_IDLE, 4'h0, 4'h0, 1'b1, K_QUIET, 4'h0, "R4");
        for (int i = 0; i < 8; i++)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b0, K_QUIET, 4'h0, "R9");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h1, "R5");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h0, "R5");

        // load wins over a step in the same cycle
        cyc(OP_LOAD_LO, 4'h0, 4'h3, 1'b1, K_NONE, 4'h0, "");
        read_both(8'h03, "R8");
        cyc(OP_LOAD_HI, 4'hA, 4'h0, 1'b1, K_NONE, 4'h0, "");
        read_both(8'hA3, "R8");

        // wrap in the same cycle as test-and-clear keeps the flag
        load_val(8'hFF);
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b1, K_TEST, 4'h0, "R5");
        read_both(8'h00, "R4");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h1, "R5");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h0, "R5");

        // unused op codes are idle
        cyc(3'd6, 4'h5, 4'h5, 1'b0, K_QUIET, 4'h0, "R9");
        cyc(3'd7, 4'h5, 4'h5, 1'b0, K_QUIET, 4'h0, "R9");
        cyc(OP_IDLE, 4'h5, 4'h5, 1'b0, K_QUIET, 4'h0, "R9");
        read_both(8'h00, "R9");

        // ---------------- event mode ----------------
        do_reset(1'b1);
        read_both(8'h00, "R1");
        for (int i = 0; i < 4; i++)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b1, K_QUIET, 4'h0, "R3");
        read_both(8'h00, "R3");

        // latency: value changes after the fourth edge
        pin_lvl = 1'b1;
        for (int i = 0; i < 4; i++)
            cyc(OP_READ_LO, 4'h0, 4'h0, 1'b0, K_LO, 4'h0, "R3");
        for (int i = 0; i < 7; i++)
            cyc(OP_READ_LO, 4'h0, 4'h0, 1'b0, K_LO, 4'h1, "R3");
        pin_lvl = 1'b0;
        for (int i = 0; i < 3; i++)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b1, K_QUIET, 4'h0, "R3");
        pin_lvl = 1'b1;
        for (int i = 0; i < 6; i++)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b0, K_QUIET, 4'h0, "R3");
        read_both(8'h02, "R3");

        // event-driven wrap
        load_val(8'hFF);
        pin_lvl = 1'b0;
        for (int i = 0; i < 3; i++)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b0, K_QUIET, 4'h0, "R4");
        pin_lvl = 1'b1;
        for (int i = 0; i < 6; i++)
            cyc(OP_IDLE, 4'h0, 4'h0, 1'b0, K_QUIET, 4'h0, "R4");
        read_both(8'h00, "R4");
        cyc(OP_TEST_CLR, 4'h0, 4'h0, 1'b0, K_TEST, 4'h1, "R4");

        cyc(OP_IDLE, 4'h0, 4'h0, 1'b0, K_NONE, 4'h0, "");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule